// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Overrides

This block is an eight-pin general-purpose I/O port with a small register bus. Each pin has a direction bit and an output latch. Pad input values reach software through a two-stage synchronizer. Other peripherals can take over pins: an LCD segment driver, an I2C controller and a timer's output-compare channels. Their control signals arrive as plain inputs. For every pin the block settles the pad output enable, the input enable and the open-drain mode. It does this from the register bits and those control signals, following a fixed priority that depends on which group the pin belongs to.

The LCD override wins on every pin and shuts both pad buffers off. On pins 6 and 5, I2C can then claim the pin as an open-drain output. On pins 3 to 0, an active output-compare channel forces the pin to a push-pull output. On pins 7 and 4, the direction bit applies directly whenever LCD is off.

Top module: `gpio_override_port`

## Requirements
- R1: With no override active, direction bit 1 sets that pin's pad_oe (push-pull, pad_od 0) and bit 0 clears it; pad_ie stays 1; pad_out always equals the output latch.
- R2: After reset the direction and data registers are 0, all reads return 0 while pad_in is 0, pad_oe and pad_od are 0, and pad_ie is all ones.
- R3: When lcd_seg_en[i] is 1, pad_oe[i], pad_ie[i] and pad_od[i] are all 0, whatever the direction bit, I2C or timer inputs say.
- R4: On pins 6 and 5 only, with LCD off and both i2c_routed and i2c_enable at 1, the pin becomes an open-drain output (pad_od 1) regardless of its direction bit; with either signal at 0 there is no effect; pad_od is never 1 on any other pin.
- R5: On pins 7 and 4, the I2C and timer inputs have no effect on pad_oe, pad_ie or pad_od.
- R6: On pin i in 3..0, with LCD off, tmr_route at 1 and tmr_oc_en[i] at 1, pad_oe[i] is 1 and pad_od[i] is 0 regardless of the direction bit.
- R7: In open-drain mode pad_oe is 1 only while the latched data bit is 0; a 1 releases the pad.
- R8: Address 2 reads the input register: bit i is pad_in[i] as it stood at the clock edge two edges earlier, ANDed with pad_ie[i]. A change of pad_in is visible after exactly two rising edges, not after one.
- R9: Address 1 reads, per pin, the output latch if the pin resolves to an output, and otherwise the synchronized pad value masked by the input enable.
- R10: Address 0 is the direction register and address 1 the data register, both written when bus_we is 1. Address 2 is read-only and writes to it change nothing. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| lcd_seg_en | input | 8 | Per-pin LCD segment output enable |
| i2c_routed | input | 1 | I2C signals are routed to this port |
| i2c_enable | input | 1 | I2C controller is enabled |
| tmr_route | input | 1 | Timer channels are routed to this port |
| tmr_oc_en | input | 4 | Output-compare enable for the timer channels on pins 3..0 |
| pad_in | input | 8 | Raw pad input values |
| pad_out | output | 8 | Value driven towards the pads |
| pad_oe | output | 8 | Pad output buffer enable |
| pad_ie | output | 8 | Pad input buffer enable |
| pad_od | output | 8 | Pad open-drain mode |

## Verification
The bench walks every priority combination in each pin group. It checks LCD against I2C and timer together, I2C with only one of its two qualifiers set, and a timer channel whose compare enable is off. A wrong priority order would leave a buffer on under LCD, or let I2C or timer claim pins outside their group. Open-drain release is checked with the data bit both at 0 and at 1. A design that kept driving the pad in open-drain mode would show pad_oe high while the latch holds 1. The input path is sampled one edge and two edges after a pad change. A synchronizer one stage short, or one stage long, fails at one of those two points. Random mixes of all controls are then compared against a bench model of the priority rules.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_INP  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    GRP_LCD_ONLY = 2'd0,
    GRP_I2C      = 2'd1,
    GRP_TMR      = 2'd2
  } pin_group_e;

  typedef struct packed {
    logic drive;  // pin resolves to an output
    logic ie;     // input buffer enabled
    logic od;     // open-drain mode
  } pin_ctl_t;

  // Which override rules apply to a pin position.
  function automatic pin_group_e group_of(input int idx);
    if (idx == 5 || idx == 6) return GRP_I2C;
    if (idx <= 3)             return GRP_TMR;
    return GRP_LCD_ONLY;
  endfunction

  // Fixed priority: LCD, then the group's own peripheral, then the direction bit.
  function automatic pin_ctl_t resolve_pin(input pin_group_e grp, input logic dir,
                                           input logic lcd, input logic i2c_act,
                                           input logic tmr_act);
    pin_ctl_t c;
    c.ie    = ~lcd;
    c.od    = 1'b0;
    c.drive = dir;
    if (lcd) begin
      c.drive = 1'b0;
    end else if (grp == GRP_I2C && i2c_act) begin
      c.drive = 1'b1;
      c.od    = 1'b1;
    end else if (grp == GRP_TMR && tmr_act) begin
      c.drive = 1'b1;
    end
    return c;
  endfunction

  // Open-drain pads only pull low; a 1 releases the pad.
  function automatic logic pad_enable(input pin_ctl_t c, input logic data);
    return c.drive & ~(c.od & data);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_port_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic dir_bit,
  input  logic data_bit,
  input  logic lcd_en,
  input  logic i2c_act,
  input  logic tmr_act,
  input  logic sync_bit,
  output logic is_out,
  output logic oe,
  output logic ie,
  output logic od,
  output logic data_rd,
  output logic inp_rd
);

  localparam pin_group_e GRP = group_of(IDX);

  pin_ctl_t ctl;

  always_comb begin
    ctl = resolve_pin(GRP, dir_bit, lcd_en, i2c_act, tmr_act);
  end

  assign is_out  = ctl.drive;
  assign ie      = ctl.ie;
  assign od      = ctl.od;
  assign oe      = pad_enable(ctl, data_bit);
  assign inp_rd  = ctl.ie & sync_bit;
  assign data_rd = ctl.drive ? data_bit : inp_rd;

endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int TMR_CH = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  lcd_seg_en,
  input  logic              i2c_routed,
  input  logic              i2c_enable,
  input  logic              tmr_route,
  input  logic [TMR_CH-1:0] tmr_oc_en,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_ie,
  output logic [NPINS-1:0]  pad_od
);

  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] in_sync;      // synchronized pad values
  logic [NPINS-1:0] tmr_act;      // per-pin timer claim
  logic [NPINS-1:0] pin_is_out;   // resolved direction
  logic [NPINS-1:0] data_rd;
  logic [NPINS-1:0] inp_rd;
  logic             i2c_act;

  assign i2c_act = i2c_routed & i2c_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_DIR)  dir_q  <= bus_wdata;
      if (bus_addr == ADDR_DATA) data_q <= bus_wdata;
    end
  end

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i < TMR_CH) begin : g_tmr
      assign tmr_act[i] = tmr_route & tmr_oc_en[i];
    end else begin : g_notmr
      assign tmr_act[i] = 1'b0;
    end

    gpio_pin_resolve #(.IDX(i)) u_pin (
      .dir_bit  (dir_q[i]),
      .data_bit (data_q[i]),
      .lcd_en   (lcd_seg_en[i]),
      .i2c_act  (i2c_act),
      .tmr_act  (tmr_act[i]),
      .sync_bit (in_sync[i]),
      .is_out   (pin_is_out[i]),
      .oe       (pad_oe[i]),
      .ie       (pad_ie[i]),
      .od       (pad_od[i]),
      .data_rd  (data_rd[i]),
      .inp_rd   (inp_rd[i])
    );
  end

  assign pad_out = data_q;

  always_comb begin
    case (bus_addr)
      ADDR_DIR:  bus_rdata = dir_q;
      ADDR_DATA: bus_rdata = data_rd;
      ADDR_INP:  bus_rdata = inp_rd;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_override_port_chk.sv
module gpio_override_port_chk #(
  parameter int NPINS  = 8,
  parameter int TMR_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  lcd_seg_en,
  input logic              tmr_route,
  input logic [TMR_CH-1:0] tmr_oc_en,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_ie,
  input logic [NPINS-1:0]  pad_od,
  input logic [NPINS-1:0]  in_sync
);

  localparam logic [NPINS-1:0] OD_PINS = NPINS'(8'h60);

  logic [1:0] live_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_cnt <= '0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end

  AST_LCD_KILLS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_seg_en & (pad_oe | pad_ie | pad_od)) == '0);  // R3

  AST_OD_GROUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & ~OD_PINS) == '0);  // R4

  AST_OD_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_oe & pad_out) == '0);  // R7

  AST_TMR_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (({TMR_CH{tmr_route}} & tmr_oc_en & ~lcd_seg_en[TMR_CH-1:0])
      & ~(pad_oe[TMR_CH-1:0] & ~pad_od[TMR_CH-1:0])) == '0);  // R6

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2'd2) |-> (in_sync == $past(pad_in, 2)));  // R8

  AST_INPUT_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata == (in_sync & pad_ie)));  // R8

endmodule

bind gpio_override_port gpio_override_port_chk #(.NPINS(NPINS), .TMR_CH(TMR_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .lcd_seg_en (lcd_seg_en),
  .tmr_route  (tmr_route),
  .tmr_oc_en  (tmr_oc_en),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_ie     (pad_ie),
  .pad_od     (pad_od),
  .in_sync    (in_sync)
);

// File: tb/gpio_override_port_test.sv
module gpio_override_port_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] lcd_seg_en = 8'h00;
  logic       i2c_routed = 1'b0;
  logic       i2c_enable = 1'b0;
  logic       tmr_route = 1'b0;
  logic [3:0] tmr_oc_en = 4'h0;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_ie, pad_od;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_dir = 8'h00;
  logic [7:0] m_data = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_override_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_seg_en(lcd_seg_en),
    .i2c_routed(i2c_routed), .i2c_enable(i2c_enable), .tmr_route(tmr_route),
    .tmr_oc_en(tmr_oc_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_od(pad_od)
  );

  // Bench model of one pin: returns {output, input enable, open drain}.
  function automatic logic [2:0] model_pin(int i, logic d, logic lcd);
    logic i2c_on, tmr_on;
    i2c_on = i2c_routed && i2c_enable && (i == 5 || i == 6);
    tmr_on = (i < 4) && tmr_route && tmr_oc_en[i];
    if (lcd)    return 3'b000;
    if (i2c_on) return 3'b111;
    if (tmr_on) return 3'b110;
    return {d, 2'b10};
  endfunction

  function automatic logic [7:0] exp_vec(int sel);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] p;
      p = model_pin(i, m_dir[i], lcd_seg_en[i]);
      case (sel)
        0: v[i] = p[2] && !(p[0] && m_data[i]);
        1: v[i] = p[1];
        default: v[i] = p[0];
      endcase
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_drive();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = model_pin(i, m_dir[i], lcd_seg_en[i])[2];
    return v;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 2'd0) m_dir = d;
    if (a == 2'd1) m_data = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Compare pads and all reads against the model; pad_in must be stable two edges.
  task automatic check_all(string tag);
    logic [7:0] r, ie;
    ie = exp_vec(1);
    chk({tag, " R1 pad_oe"}, pad_oe, exp_vec(0));
    chk({tag, " R3 pad_ie"}, pad_ie, ie);
    chk({tag, " R4 pad_od"}, pad_od, exp_vec(2));
    chk({tag, " R1 pad_out"}, pad_out, m_data);
    rd(2'd0, r); chk({tag, " R10 dir read"}, r, m_dir);
    rd(2'd2, r); chk({tag, " R8 input read"}, r, pad_in & ie);
    rd(2'd1, r);
    chk({tag, " R9 data read"}, r, (m_data & exp_drive()) | (pad_in & ie & ~exp_drive()));
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 pad_oe", pad_oe, 8'h00);
    chk("R2 pad_od", pad_od, 8'h00);
    chk("R2 pad_ie", pad_ie, 8'hFF);
    rd(2'd0, r); chk("R2 dir", r, 8'h00);
    rd(2'd1, r); chk("R2 data", r, 8'h00);
    rd(2'd2, r); chk("R2 input", r, 8'h00);

    // R1 plain direction
    wr(2'd0, 8'h5A); wr(2'd1, 8'hFF);
    chk("R1 oe follows dir", pad_oe, 8'h5A);
    chk("R1 pad_out latch", pad_out, 8'hFF);
    chk("R1 no od", pad_od, 8'h00);

    // R10 input register is read-only, addr 3 reads 0
    wr(2'd2, 8'hFF);
    rd(2'd2, r); chk("R10 input write ignored", r, 8'h00);
    rd(2'd0, r); chk("R10 dir untouched", r, 8'h5A);
    rd(2'd1, r); chk("R10 data untouched", r, 8'h5A);
    rd(2'd3, r); chk("R10 addr3 zero", r, 8'h00);

    // R9 mixed read
    @(negedge clk); pad_in = 8'h0F; settle();
    rd(2'd1, r); chk("R9 mixed data read", r, 8'h5F);

    // R8 exact latency
    wr(2'd0, 8'h00);
    @(negedge clk); pad_in = 8'h00; settle();
    @(negedge clk); pad_in = 8'hA5;
    @(posedge clk); #1;
    rd(2'd2, r); chk("R8 one edge not yet", r, 8'h00);
    @(posedge clk); #1;
    rd(2'd2, r); chk("R8 two edges visible", r, 8'hA5);
    rd(2'd1, r); chk("R9 input pins read sync", r, 8'hA5);

    // R3 LCD beats everything
    @(negedge clk);
    lcd_seg_en = 8'hFF; i2c_routed = 1; i2c_enable = 1; tmr_route = 1; tmr_oc_en = 4'hF;
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    chk("R3 lcd oe", pad_oe, 8'h00);
    chk("R3 lcd ie", pad_ie, 8'h00);
    chk("R3 lcd od", pad_od, 8'h00);
    rd(2'd2, r); chk("R3 lcd input read", r, 8'h00);

    // R4 I2C needs both qualifiers
    lcd_seg_en = 8'h00; tmr_route = 0; wr(2'd0, 8'h00);
    i2c_enable = 0; #1; chk("R4 enable low no od", pad_od, 8'h00);
    i2c_enable = 1; i2c_routed = 0; #1; chk("R4 routed low no od", pad_od, 8'h00);
    i2c_routed = 1; #1; chk("R4 od on 6 and 5", pad_od, 8'h60);
    chk("R7 od drives low", pad_oe, 8'h60);
    wr(2'd1, 8'hFF);
    chk("R7 od releases high", pad_oe, 8'h00);
    lcd_seg_en = 8'h20; #1;
    chk("R3 lcd over i2c", pad_od, 8'h40);

    // R5 pins 7 and 4 ignore i2c and timer
    lcd_seg_en = 8'h00; tmr_route = 1; tmr_oc_en = 4'hF; #1;
    chk("R5 pins 7,4 oe", pad_oe & 8'h90, 8'h00);
    chk("R5 pins 7,4 ie", pad_ie & 8'h90, 8'h90);

    // R6 timer
    i2c_routed = 0; tmr_oc_en = 4'h5; #1;
    chk("R6 timer forces out", pad_oe, 8'h05);
    tmr_route = 0; #1;
    chk("R6 route off", pad_oe, 8'h00);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      lcd_seg_en = 8'($urandom) & 8'($urandom);
      i2c_routed = 1'($urandom); i2c_enable = 1'($urandom);
      tmr_route = 1'($urandom); tmr_oc_en = 4'($urandom);
      pad_in = 8'($urandom);
      wr(2'd0, 8'($urandom));
      wr(2'd1, 8'($urandom));
      settle();
      check_all("rand R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule